// File: doc/BRIEF.md
# Asynchronous Byte-Wide Non-Volatile Memory Controller

This block sits on the synchronous side of a chip and runs an external asynchronous, SRAM-compatible non-volatile memory that is one byte wide. The host issues one request at a time through a valid/ready handshake that carries an address, a write byte and a direction flag. The controller then drives the memory's active-low chip select, write strobe and output-drive strobe, its address bus and its data bus. The data bus is split into an output, an output enable and an input, so that the pad cell sits outside the block. Reads return their byte with a single-cycle valid pulse.

Each nanosecond minimum of the memory is a parameter. The controller turns each one into a clock count by ceiling division by the clock period, and holds each strobe phase for that count. Writes are always terminated by the write strobe, and the output-drive strobe stays high while a write is in progress. A power-good input from a separate sequencer gates acceptance, so no cycle starts before the memory has finished its start-up.

Top module: `async_nvm_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, chip select, write strobe and output-drive strobe are all high (inactive), the data output enable is low and the response valid is low.
- R2: `req_ready_o` is high only when the controller is idle and `pwr_ok_i` is high. A request presented while `pwr_ok_i` is low starts no memory cycle: all strobes stay high.
- R3: A read drives chip select and output-drive strobe low together, with the write strobe high. Both stay low for RD_LOW = max(ceil(35/T), ceil(15/T), 1) cycles, and `mem_dq_i` is sampled on the clock edge that ends that phase. T is the clock period in ns.
- R4: `rsp_valid_o` goes high in the cycle that follows the last read-strobe cycle. It stays high for exactly one cycle, with the sampled byte on `rsp_rdata_o`.
- R5: A write drives chip select and write strobe low together for WR_LOW = max(ceil(15/T), ceil(18/T), ceil(10/T), 1) cycles. The output-drive strobe stays high whenever the write strobe is low.
- R6: `mem_dq_en_o` is high exactly in the cycles where the write strobe is low, and during those cycles `mem_dq_o` holds the write byte of the request.
- R7: While chip select stays low, `mem_addr_o` does not change. After the write strobe rises, the next chip-select fall comes no sooner than ceil(12/T) cycles later.
- R8: Successive chip-select falls are at least ceil(35/T) cycles apart, and every strobe stays high for at least max(ceil(2/T), 1) cycles between assertions.
- R9: A read of an address returns the byte most recently written there through the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_ok_i | input | 1 | Memory power and start-up complete |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DATA_W | Read byte |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output-drive strobe, active low |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_en_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
The assertions assume that `pwr_ok_i` only changes while no cycle is in progress. They also assume that request fields are meaningful only in the cycle of acceptance, so any change to them outside that cycle must leave the strobes and address untouched. The bench raises and lowers power only between requests, holds its request fields until acceptance and then withdraws the request. Its memory model returns a corrupt byte when a read has not yet been held long enough, and it stores the inverted byte when a write strobe is too short. Timing faults therefore show up as read-back mismatches as well as in direct strobe measurements.

// File: rtl/nvm_ctrl_pkg.sv
`timescale 1ns/1ps
package nvm_ctrl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE, PH_RECOV} phase_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub0(int unsigned a, int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction
endpackage

// File: rtl/nvm_phase_timer.sv
`timescale 1ns/1ps
module nvm_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvm_strobe_seq.sv
`timescale 1ns/1ps
module nvm_strobe_seq
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned RD_LOW = 4,
  parameter int unsigned WR_LOW = 2,
  parameter int unsigned RD_GAP = 1,
  parameter int unsigned WR_GAP = 2,
  parameter int unsigned CNT_W  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic we_i,
  output logic busy_o,
  output logic cap_o,
  output logic wr_end_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no
);
  phase_e           ph_q;
  logic             zero;
  logic             load;
  logic [CNT_W-1:0] load_val;

  assign cap_o    = (ph_q == PH_READ)  && zero;
  assign wr_end_o = (ph_q == PH_WRITE) && zero;
  assign busy_o   = (ph_q != PH_IDLE);

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (accept_i) begin
      load     = 1'b1;
      load_val = we_i ? CNT_W'(WR_LOW - 1) : CNT_W'(RD_LOW - 1);
    end else if (cap_o) begin
      load     = 1'b1;
      load_val = CNT_W'(RD_GAP - 1);
    end else if (wr_end_o) begin
      load     = 1'b1;
      load_val = CNT_W'(WR_GAP - 1);
    end
  end

  nvm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      ce_no <= 1'b1;
      we_no <= 1'b1;
      oe_no <= 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (accept_i) begin
          ph_q  <= we_i ? PH_WRITE : PH_READ;
          ce_no <= 1'b0;
          we_no <= !we_i;
          oe_no <= we_i;   // output drive stays off for writes
        end
        PH_READ, PH_WRITE: if (zero) begin
          ph_q  <= PH_RECOV;
          ce_no <= 1'b1;
          we_no <= 1'b1;
          oe_no <= 1'b1;
        end
        PH_RECOV: if (zero) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_bus_dpath.sv
`timescale 1ns/1ps
module nvm_bus_dpath #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic              wr_end_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o      <= '0;
      dq_o        <= '0;
      dq_en_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= cap_i;
      if (cap_i) rsp_rdata_o <= dq_i;
      if (accept_i) begin
        addr_o <= addr_i;
        if (we_i) dq_o <= wdata_i;
      end
      if (accept_i && we_i) dq_en_o <= 1'b1;
      else if (wr_end_i)    dq_en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/async_nvm_ctrl.sv
`timescale 1ns/1ps
module async_nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 21,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_CYC_NS = 35,
  parameter int unsigned T_ACC_NS = 35,
  parameter int unsigned T_OE_NS  = 15,
  parameter int unsigned T_WP_NS  = 15,
  parameter int unsigned T_AW_NS  = 18,
  parameter int unsigned T_DS_NS  = 10,
  parameter int unsigned T_REC_NS = 12,
  parameter int unsigned T_HI_NS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_en_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned CYC_CNT = ns2cyc(T_CYC_NS, CLK_NS);
  localparam int unsigned HI_CNT  = umax(ns2cyc(T_HI_NS, CLK_NS), 1);
  localparam int unsigned REC_CNT = ns2cyc(T_REC_NS, CLK_NS);
  localparam int unsigned RD_LOW  = umax(umax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)), 1);
  localparam int unsigned WR_LOW  = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                         umax(ns2cyc(T_DS_NS, CLK_NS), 1));
  localparam int unsigned RD_GAP  = umax(HI_CNT, usub0(CYC_CNT, RD_LOW));
  localparam int unsigned WR_GAP  = umax(umax(HI_CNT, REC_CNT), usub0(CYC_CNT, WR_LOW));
  localparam int unsigned MAX_CNT = umax(umax(RD_LOW, WR_LOW), umax(RD_GAP, WR_GAP));
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic busy, accept, cap, wr_end;

  assign req_ready_o = !busy && pwr_ok_i;
  assign accept      = req_valid_i && req_ready_o;

  nvm_strobe_seq #(
    .RD_LOW (RD_LOW),
    .WR_LOW (WR_LOW),
    .RD_GAP (RD_GAP),
    .WR_GAP (WR_GAP),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .we_i     (req_we_i),
    .busy_o   (busy),
    .cap_o    (cap),
    .wr_end_o (wr_end),
    .ce_no    (mem_ce_no),
    .we_no    (mem_we_no),
    .oe_no    (mem_oe_no)
  );

  nvm_bus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .we_i        (req_we_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .cap_i       (cap),
    .wr_end_i    (wr_end),
    .dq_i        (mem_dq_i),
    .addr_o      (mem_addr_o),
    .dq_o        (mem_dq_o),
    .dq_en_o     (mem_dq_en_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/async_nvm_ctrl_chk.sv
`timescale 1ns/1ps
module async_nvm_ctrl_chk #(
  parameter int unsigned ADDR_W  = 21,
  parameter int unsigned CYC_CNT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_ok_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_dq_en_o
);
  logic        ce_q;
  int unsigned since_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q       <= 1'b1;
      since_fall <= CYC_CNT;
    end else begin
      ce_q <= mem_ce_no;
      if (ce_q && !mem_ce_no)     since_fall <= 1;
      else if (since_fall < CYC_CNT) since_fall <= since_fall + 1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_we_no && mem_oe_no && !mem_dq_en_o));

  a_r2_no_ready_without_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |-> !req_ready_o);

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r5_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && !mem_ce_no));

  a_r6_drive_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_en_o == !mem_we_no);

  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !ce_q) |-> $stable(mem_addr_o));

  a_r8_ce_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_q && !mem_ce_no) |-> (since_fall >= CYC_CNT));
endmodule

bind async_nvm_ctrl async_nvm_ctrl_chk #(.ADDR_W(ADDR_W), .CYC_CNT(CYC_CNT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_ok_i    (pwr_ok_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_en_o (mem_dq_en_o)
);

// File: tb/tb_async_nvm_ctrl.sv
`timescale 1ns/1ps
module tb_async_nvm_ctrl;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int TCK = 20;
  localparam int DEPTH = 1 << AW;

  function automatic int cdiv(int ns); return (ns + TCK - 1) / TCK; endfunction
  function automatic int imax(int a, int b); return a > b ? a : b; endfunction

  localparam int E_RD  = imax(imax(cdiv(35), cdiv(15)), 1);
  localparam int E_WR  = imax(imax(cdiv(15), cdiv(18)), imax(cdiv(10), 1));
  localparam int E_CYC = cdiv(35);
  localparam int E_REC = cdiv(12);
  localparam int E_HI  = imax(cdiv(2), 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ce_n, we_n, oe_n, dq_en;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] shadow[DEPTH];
  logic [DW-1:0] cur_wdata = '0;
  int rd_run = 0, oe_run = 0, we_run = 0, hi_run = 100, since_fall = 100, since_we_rise = 100;
  logic prev_ce = 1'b1, prev_we = 1'b1;
  logic [AW-1:0] prev_addr = '0, wa = '0;
  logic [DW-1:0] wd = '0;

  always #(TCK/2) clk = ~clk;

  async_nvm_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(TCK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_addr_o(mem_addr), .mem_dq_o(dq_o), .mem_dq_en_o(dq_en), .mem_dq_i(dq_i));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: data valid only after a full access time
  assign dq_i = (!ce_n && !oe_n && we_n && rd_run >= E_RD) ? mem[mem_addr] : 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n && !oe_n && we_n) rd_run++; else rd_run = 0;
      if (!oe_n) oe_run++;
      else if (oe_run > 0) begin chk(oe_run == E_RD, "R3 read strobe length", oe_run, E_RD); oe_run = 0; end
      if (!we_n) begin
        we_run++; wa = mem_addr; wd = dq_o;
        chk(oe_n && !ce_n, "R5 oe high during write", int'(oe_n), 1);
        chk(dq_en && dq_o == cur_wdata, "R6 write drive", int'(dq_o), int'(cur_wdata));
      end else begin
        if (dq_en) chk(1'b0, "R6 drive without write strobe", 1, 0);
        if (we_run > 0) begin
          chk(we_run == E_WR, "R5 write strobe length", we_run, E_WR);
          mem[wa] = (we_run >= E_WR) ? wd : ~wd;
          we_run = 0;
        end
      end
      if (!prev_we && we_n) since_we_rise = 0; else since_we_rise++;
      if (prev_ce && !ce_n) begin
        chk(since_fall >= E_CYC, "R8 chip select spacing", since_fall, E_CYC);
        chk(hi_run >= E_HI, "R8 strobe high time", hi_run, E_HI);
        chk(since_we_rise >= E_REC, "R7 write recovery", since_we_rise, E_REC);
        since_fall = 1;
      end else since_fall++;
      if (!ce_n && !prev_ce) chk(mem_addr == prev_addr, "R7 address stable", int'(mem_addr), int'(prev_addr));
      if (ce_n) hi_run++; else hi_run = 0;
      prev_ce = ce_n; prev_we = we_n; prev_addr = mem_addr;
    end
  end

  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    if (we) cur_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      shadow[a] = d;
      while (!req_ready) @(negedge clk);
    end else begin
      k = 0;
      while (!rsp_valid && k < 50) begin @(negedge clk); k++; end
      chk(k == E_RD, "R4 response latency", k, E_RD);
      chk(rsp_rdata == shadow[a], "R9 read back", int'(rsp_rdata), int'(shadow[a]));
      @(negedge clk);
      chk(!rsp_valid, "R4 one-cycle pulse", int'(rsp_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_en && !rsp_valid, "R1 reset state", int'({ce_n, we_n, oe_n, dq_en, rsp_valid}), 5'b11100);
    // R2: no power, request must not start a cycle
    req_valid = 1'b1; req_we = 1'b1; req_addr = 4'h3; req_wdata = 8'h5A;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!req_ready && ce_n && we_n, "R2 held off without power", int'({req_ready, ce_n, we_n}), 3'b011);
    end
    req_valid = 1'b0;
    pwr_ok = 1'b1;
    @(negedge clk);
    chk(req_ready, "R2 ready with power", int'(req_ready), 1);
    chk(mem[3] == 8'h00, "R2 ignored request left memory", int'(mem[3]), 0);
    for (int a = 0; a < DEPTH; a++) do_req(1'b1, AW'(a), DW'(a * 29 + 7));
    for (int a = 0; a < DEPTH; a++) do_req(1'b0, AW'(a), 8'h00);
    for (int a = DEPTH - 1; a >= 0; a--) begin
      do_req(1'b1, AW'(a), ~DW'(a * 53 + 1));
      do_req(1'b0, AW'(a), 8'h00);
    end
    for (int v = 0; v < 256; v += 17) begin
      do_req(1'b1, 4'hA, DW'(v));
      do_req(1'b0, 4'hA, 8'h00);
    end
    @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_en, "R1 idle state", int'({ce_n, we_n, oe_n, dq_en}), 4'b1110);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule